// File: doc/BRIEF.md
# TDR Pulse Transmit Sequencer

This block fires a single test pulse onto one of two cable pairs for a time-domain reflectometry measurement, and tells the reflection monitor when to start its timer. Software sets a group of control fields: an enable that hands both line drivers to the block, a driver mode, a pair select, a width code and a send strobe. A rising edge on the send strobe launches one shot. The block runs on a 125 MHz clock, so one clock is 8 ns.

In fast mode the shot drives the data-driver outputs for as many clocks as the width code, up to 7 clocks (56 ns). Each fast shot has the opposite polarity to the previous one. In slow mode the shot is a link pulse on its own output line, rounded to either a short or a long clock count. A width code of zero drives nothing but still pulses the monitor start, so that the background level on the line can be captured as a baseline.

Top module: `tdr_pulse_seq`

## Requirements
- R1: After reset, every pulse output, `monitor_start`, `pulse_busy` and `drv_takeover` are low, and the first fast shot is positive.
- R2: `drv_takeover` equals `tdr_en` delayed by one clock.
- R3: A shot launches only on a clock where `send_req` is high, it was low on the clock before, and `tdr_en` is high. Holding `send_req` high launches only one shot.
- R4: With `fast_mode` = 1 and a width code N of 1 to 7, the selected fast output is high for exactly N consecutive clocks.
- R5: With `fast_mode` = 0, a width code of 1 to 3 drives `link_pulse` for 7 clocks, and a code of 4 to 7 drives it for 13 clocks.
- R6: `pair_sel` = 0 routes the shot to index 0 (transmit pair) of each output vector, and `pair_sel` = 1 routes it to index 1 (receive pair). At most one output line is high at any time.
- R7: A width code of 0 raises `monitor_start` for one clock and drives no pulse line.
- R8: `monitor_start` is high for exactly one clock, and it is the clock in which the first pulse cycle appears.
- R9: Successive fast shots alternate between `fast_pos` and `fast_neg`. Zero-width shots and slow shots leave the alternation unchanged.
- R10: A send edge is ignored while a shot is in progress or while `tdr_en` is low.
- R11: Clearing `tdr_en` during a shot ends the pulse on the next clock edge. That shot still counts for the polarity alternation.
- R12: Mode, pair and width are captured when the shot launches. Changes to these inputs during the shot do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| tdr_en | input | 1 | Hands both line drivers to the block |
| fast_mode | input | 1 | 1 selects data-driver pulses, 0 selects link pulses |
| pair_sel | input | 1 | 0 selects the transmit pair, 1 selects the receive pair |
| send_req | input | 1 | A rising edge requests one shot |
| pulse_width | input | 3 | Width code, 0 to 7 |
| drv_takeover | output | 1 | Drivers are owned by the block |
| fast_pos | output | 2 | Positive data-driver pulse, one bit per pair |
| fast_neg | output | 2 | Negative data-driver pulse, one bit per pair |
| link_pulse | output | 2 | Link pulse, one bit per pair |
| monitor_start | output | 1 | One-clock start for the reflection monitor timer |
| pulse_busy | output | 1 | A shot is in progress |

## Verification
The bench builds the block with its default lengths: 7 clocks for the short link pulse, 13 for the long one, and code 4 as the first long code. With these values the longest shot (13 clocks) is long enough for the bench to fire a second send edge in the middle of it and change the mode and pair inputs while it runs. The boundary between codes 3 and 4 is tested on both sides. An abort partway through a 7-clock fast shot checks both the shortened length and the polarity of the shot that follows.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int NUM_PAIRS = 2;
    localparam int CODE_W    = 3;

    typedef enum logic {
        DRV_LINK = 1'b0,
        DRV_FAST = 1'b1
    } drv_mode_e;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pol_e;

    typedef struct packed {
        drv_mode_e mode;
        logic      pair;
        pol_e      pol;
    } shot_t;

    // Clock count for one shot; zero means no line is driven.
    function automatic int shot_clocks(input drv_mode_e mode,
                                       input logic [CODE_W-1:0] code,
                                       input int short_clks,
                                       input int long_clks,
                                       input int long_min_code);
        if (code == '0)
            return 0;
        if (mode == DRV_FAST)
            return int'(code);
        if (int'(code) >= long_min_code)
            return long_clks;
        return short_clks;
    endfunction

endpackage

// File: rtl/tdr_launch.sv
module tdr_launch (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic send_req,
    input  logic busy,
    output logic fire
);
    logic send_prev;

    always_ff @(posedge clk) begin
        if (rst)
            send_prev <= 1'b0;
        else
            send_prev <= send_req;
    end

    assign fire = enable && send_req && !send_prev && !busy;
endmodule

// File: rtl/tdr_shot_timer.sv
module tdr_shot_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             abort,
    output logic             active
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
        end else if (abort) begin
            active <= 1'b0;
            remain <= '0;
        end else if (load) begin
            active <= 1'b1;
            remain <= load_len - CNT_W'(1);
        end else if (active) begin
            if (remain == '0)
                active <= 1'b0;
            else
                remain <= remain - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tdr_drive_map.sv
module tdr_drive_map
    import tdr_pkg::*;
#(
    parameter int PAIRS = 2
) (
    input  logic             active,
    input  shot_t            shot,
    output logic [PAIRS-1:0] fast_pos,
    output logic [PAIRS-1:0] fast_neg,
    output logic [PAIRS-1:0] link_pulse
);
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic here;
        assign here          = active && (int'(shot.pair) == p);
        assign fast_pos[p]   = here && shot.mode == DRV_FAST && shot.pol == POL_POS;
        assign fast_neg[p]   = here && shot.mode == DRV_FAST && shot.pol == POL_NEG;
        assign link_pulse[p] = here && shot.mode == DRV_LINK;
    end
endmodule

// File: rtl/tdr_pulse_seq.sv
module tdr_pulse_seq
    import tdr_pkg::*;
#(
    parameter int LINK_SHORT_CLKS    = 7,
    parameter int LINK_LONG_CLKS     = 13,
    parameter int LINK_LONG_MIN_CODE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tdr_en,
    input  logic       fast_mode,
    input  logic       pair_sel,
    input  logic       send_req,
    input  logic [2:0] pulse_width,
    output logic       drv_takeover,
    output logic [1:0] fast_pos,
    output logic [1:0] fast_neg,
    output logic [1:0] link_pulse,
    output logic       monitor_start,
    output logic       pulse_busy
);
    localparam int MAX_CLKS = (LINK_LONG_CLKS > 7) ? LINK_LONG_CLKS : 7;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    logic             fire;
    logic             active;
    logic             load;
    logic [CNT_W-1:0] len;
    drv_mode_e        mode_in;
    pol_e             next_pol;
    shot_t            shot_q;
    logic             mstart_q;
    logic             take_q;

    assign mode_in = drv_mode_e'(fast_mode);

    tdr_launch u_launch (
        .clk      (clk),
        .rst      (rst),
        .enable   (tdr_en),
        .send_req (send_req),
        .busy     (active),
        .fire     (fire)
    );

    assign len  = CNT_W'(shot_clocks(mode_in, pulse_width, LINK_SHORT_CLKS,
                                     LINK_LONG_CLKS, LINK_LONG_MIN_CODE));
    assign load = fire && (len != '0);

    tdr_shot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_len (len),
        .abort    (!tdr_en),
        .active   (active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shot_q   <= '{mode: DRV_LINK, pair: 1'b0, pol: POL_POS};
            next_pol <= POL_POS;
            mstart_q <= 1'b0;
            take_q   <= 1'b0;
        end else begin
            mstart_q <= fire;
            take_q   <= tdr_en;
            if (load) begin
                shot_q <= '{mode: mode_in, pair: pair_sel, pol: next_pol};
                if (mode_in == DRV_FAST)
                    next_pol <= (next_pol == POL_POS) ? POL_NEG : POL_POS;
            end
        end
    end

    tdr_drive_map #(.PAIRS(NUM_PAIRS)) u_map (
        .active     (active),
        .shot       (shot_q),
        .fast_pos   (fast_pos),
        .fast_neg   (fast_neg),
        .link_pulse (link_pulse)
    );

    assign monitor_start = mstart_q;
    assign pulse_busy    = active;
    assign drv_takeover  = take_q;
endmodule

// File: rtl/tdr_pulse_seq_chk.sv
module tdr_pulse_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       tdr_en,
    input logic       send_req,
    input logic [1:0] fast_pos,
    input logic [1:0] fast_neg,
    input logic [1:0] link_pulse,
    input logic       monitor_start,
    input logic       pulse_busy
);
    // R8
    mstart_single_chk: assert property (@(posedge clk) disable iff (rst)
        monitor_start |=> !monitor_start);

    // R8
    mstart_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_busy) |-> monitor_start);

    // R6
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({fast_pos, fast_neg, link_pulse}) <= 1);

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        !tdr_en |=> !pulse_busy);

    // R3
    start_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        monitor_start |-> ($past(send_req) && $past(tdr_en)));
endmodule

bind tdr_pulse_seq tdr_pulse_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tdr_en        (tdr_en),
    .send_req      (send_req),
    .fast_pos      (fast_pos),
    .fast_neg      (fast_neg),
    .link_pulse    (link_pulse),
    .monitor_start (monitor_start),
    .pulse_busy    (pulse_busy)
);

// File: tb/tdr_pulse_seq_tb.sv
module tdr_pulse_seq_tb;
    localparam int SHORT_C = 7;
    localparam int LONG_C  = 13;
    localparam int LONG_MIN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tdr_en = 1'b0, fast_mode = 1'b0, pair_sel = 1'b0, send_req = 1'b0;
    logic [2:0] pulse_width = 3'd0;
    logic       drv_takeover, monitor_start, pulse_busy;
    logic [1:0] fast_pos, fast_neg, link_pulse;

    always #10 clk = ~clk;

    tdr_pulse_seq #(.LINK_SHORT_CLKS(SHORT_C), .LINK_LONG_CLKS(LONG_C),
                    .LINK_LONG_MIN_CODE(LONG_MIN)) u_dut (
        .clk(clk), .rst(rst), .tdr_en(tdr_en), .fast_mode(fast_mode),
        .pair_sel(pair_sel), .send_req(send_req), .pulse_width(pulse_width),
        .drv_takeover(drv_takeover), .fast_pos(fast_pos), .fast_neg(fast_neg),
        .link_pulse(link_pulse), .monitor_start(monitor_start), .pulse_busy(pulse_busy)
    );

    typedef struct {
        int       len;
        logic [5:0] vec;
        string    req;
    } exp_t;

    exp_t expq[$];
    int   tests = 0, fails = 0, ev_count = 0, exp_count = 0;
    logic model_neg = 1'b0;
    bit   done = 1'b0;

    // Vector layout: {fast_pos[1:0], fast_neg[1:0], link_pulse[1:0]}
    task automatic push_exp(input logic fm, input logic pr, input logic [2:0] w,
                            input int len_override, input string req);
        exp_t e;
        e.req = req;
        e.vec = '0;
        if (w == 0) e.len = 0;
        else if (fm) e.len = int'(w);
        else e.len = (int'(w) >= LONG_MIN) ? LONG_C : SHORT_C;
        if (len_override >= 0 && e.len != 0) e.len = len_override;
        if (e.len != 0) begin
            if (!fm) e.vec[pr] = 1'b1;
            else if (!model_neg) e.vec[4 + pr] = 1'b1;
            else e.vec[2 + pr] = 1'b1;
            if (fm) model_neg = ~model_neg;
        end
        expq.push_back(e);
        exp_count++;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic shot(input logic fm, input logic pr, input logic [2:0] w,
                        input bit hold, input string req);
        @(negedge clk);
        tdr_en = 1'b1; fast_mode = fm; pair_sel = pr; pulse_width = w; send_req = 1'b0;
        @(negedge clk);
        send_req = 1'b1;
        push_exp(fm, pr, w, -1, req);
        if (!hold) begin
            @(negedge clk);
            send_req = 1'b0;
        end
        drain();
        send_req = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor / scoreboard
    bit         tracking = 1'b0;
    logic [5:0] cur;
    int         run_len;

    task automatic compare(input int len, input logic [5:0] v);
        exp_t e;
        if (expq.size() == 0) begin
            tests++; fails++;
            $display("FAIL R3 unexpected shot actual_len=%0d vec=%b expected=none", len, v);
        end else begin
            e = expq.pop_front();
            tests++;
            if (e.len != len || e.vec != v) begin
                fails++;
                $display("FAIL %s actual len=%0d vec=%b expected len=%0d vec=%b",
                         e.req, len, v, e.len, e.vec);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic [5:0] v;
            v = {fast_pos, fast_neg, link_pulse};
            if (monitor_start) begin
                ev_count++;
                if (v == 0) compare(0, v);
                else begin tracking = 1'b1; cur = v; run_len = 1; end
            end else if (tracking) begin
                if (v == cur) run_len++;
                else begin
                    compare(run_len, cur);
                    tracking = 1'b0;
                    if (v != 0) begin
                        tests++; fails++;
                        $display("FAIL R6 actual vec=%b expected=000000", v);
                    end
                end
            end else if (v != 0) begin
                tests++; fails++;
                $display("FAIL R8 pulse without start actual vec=%b expected=000000", v);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check({fast_pos, fast_neg, link_pulse, monitor_start, pulse_busy, drv_takeover} == 0,
              "R1 reset outputs", int'({fast_pos, fast_neg, link_pulse}), 0);
        // R2: takeover follows enable one clock later
        tdr_en = 1'b1;
        @(negedge clk);
        check(drv_takeover == 1'b1, "R2 takeover set", int'(drv_takeover), 1);
        tdr_en = 1'b0;
        @(negedge clk);
        check(drv_takeover == 1'b0, "R2 takeover clear", int'(drv_takeover), 0);

        shot(1, 0, 3'd3, 0, "R4 R1 fast w3 first positive");
        shot(1, 1, 3'd7, 0, "R4 R6 R9 fast w7 pair1 neg");
        shot(1, 0, 3'd1, 0, "R4 R9 fast w1 pos");
        shot(1, 0, 3'd0, 0, "R7 zero width");
        shot(1, 1, 3'd2, 0, "R9 fast after zero");
        shot(0, 1, 3'd2, 0, "R5 R6 slow w2 pair1");
        shot(0, 0, 3'd3, 0, "R5 slow w3 short");
        shot(0, 0, 3'd4, 0, "R5 slow w4 long");
        shot(0, 1, 3'd7, 0, "R5 slow w7 long");
        shot(0, 0, 3'd0, 0, "R7 slow zero width");
        shot(1, 0, 3'd5, 0, "R9 fast after slow");
        // R3: held strobe gives one shot only
        shot(0, 0, 3'd1, 1, "R3 held strobe");
        repeat (20) @(negedge clk);
        send_req = 1'b0;
        check(ev_count == exp_count, "R3 held strobe single start", ev_count, exp_count);

        // R10: strobe with enable low
        @(negedge clk);
        tdr_en = 1'b0; pulse_width = 3'd3; fast_mode = 1'b1;
        @(negedge clk); send_req = 1'b1;
        @(negedge clk); send_req = 1'b0;
        repeat (10) @(negedge clk);
        check(ev_count == exp_count, "R10 disabled strobe", ev_count, exp_count);

        // R10 R12: strobe and input changes during a long slow shot
        @(negedge clk);
        tdr_en = 1'b1; fast_mode = 1'b0; pair_sel = 1'b1; pulse_width = 3'd6;
        @(negedge clk); send_req = 1'b1;
        push_exp(0, 1, 3'd6, -1, "R10 R12 mid-shot strobe");
        @(negedge clk); send_req = 1'b0;
        repeat (3) @(negedge clk);
        fast_mode = 1'b1; pair_sel = 1'b0; pulse_width = 3'd1;
        send_req = 1'b1;
        @(negedge clk); send_req = 1'b0;
        drain();
        check(ev_count == exp_count, "R10 mid-shot start count", ev_count, exp_count);

        // R11: abort by clearing enable
        @(negedge clk);
        tdr_en = 1'b1; fast_mode = 1'b1; pair_sel = 1'b1; pulse_width = 3'd7;
        @(negedge clk); send_req = 1'b1;
        push_exp(1, 1, 3'd7, 2, "R11 abort");
        @(negedge clk); send_req = 1'b0;
        @(negedge clk); tdr_en = 1'b0;
        drain();
        check(pulse_busy == 1'b0, "R11 busy after abort", int'(pulse_busy), 0);
        shot(1, 0, 3'd2, 0, "R11 R9 polarity after abort");

        check(expq.size() == 0, "R8 scoreboard drained", expq.size(), 0);
        check(ev_count == exp_count, "R8 total starts", ev_count, exp_count);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule